// File: doc/BRIEF.md
# Multilevel Trigger Sequencer

This block decides the moment an on-chip logic analyzer fires. The probed signals are compared against a chain of ordered trigger levels. Each level gives every probe bit a condition: a logic level, a rising, falling or either edge, or don't-care. An optional term on the external trigger input can join the level's condition. A level joins its relevant terms with AND or OR. It can also require several matching samples, counted by an event counter, before it counts as satisfied.

The sequencer starts at level 0 after an arm pulse. It moves forward at most one level per sample clock. When the last level is satisfied, it raises a one-cycle trigger pulse that drives both the capture buffer and the trigger-out pin. It then stays idle and ignores the probes until it is armed again. Configuration arrives as flat vectors that hold still while the sequencer runs. How those vectors are loaded is not part of this block.

Top module: `trig_sequencer`

## Requirements
- R1: While reset is low and after its release, `trigOut` and `running` are 0 and `levelIdx` is 0.
- R2: An `arm` pulse at a clock edge sets `running`, returns `levelIdx` to 0, clears the event counter and forgets the previous sample. The probe value in the arm cycle is not evaluated. Re-arming at any time restarts the sequence.
- R3: Condition code 3'b001 matches when the probe bit is 0 and 3'b010 matches when it is 1, both on the current sample. The code for level l, bit b sits at `condCfg[(l*PROBE_W+b)*3 +: 3]`.
- R4: Code 3'b011 matches a 0 to 1 change, 3'b100 a 1 to 0 change and 3'b101 either change, each against the previous running sample. The first sample after arming never matches an edge code.
- R5: With `orMode[l]`=0 every relevant term of level l must match. With `orMode[l]`=1 any single relevant term is enough.
- R6: Codes 3'b000, 3'b110 and 3'b111 are don't-care. A level whose bits are all don't-care and whose external term is off matches on every sample.
- R7: With `extUse[l]`=1, `extTrigIn` high is one relevant, matching term of level l.
- R8: Level l is satisfied on the Nth matching sample, where N is `countCfg[l*CNT_W +: CNT_W]` and a value of 0 counts as 1. The matching samples need not be consecutive. The counter restarts at each level change.
- R9: `levelIdx` advances by exactly one on the clock edge at which its level is satisfied, and never by more than one per clock.
- R10: `trigOut` is high for exactly one cycle, the cycle after the last level is satisfied. At that same edge `running` drops, and later matches have no effect until the next arm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm | input | 1 | Start or restart the sequence at level 0 |
| probe | input | PROBE_W | Monitored signals |
| extTrigIn | input | 1 | External trigger term |
| condCfg | input | NUM_LEVELS*PROBE_W*3 | Per-level, per-bit condition codes |
| orMode | input | NUM_LEVELS | Per-level combine mode, 1 = OR |
| extUse | input | NUM_LEVELS | Per-level use of the external term |
| countCfg | input | NUM_LEVELS*CNT_W | Per-level required match count |
| trigOut | output | 1 | One-cycle trigger pulse |
| running | output | 1 | Sequencer armed and not yet fired |
| levelIdx | output | $clog2(NUM_LEVELS) | Current trigger level |

## Verification
Some rules are checked by assertions on every cycle. Arming always lands on level 0 with `running` set. The level index never jumps by more than one. The trigger pulse is one cycle wide, and it only follows a running sequencer sitting on the last level. The event counter is empty after every clear. Other behaviour is shown only by the bench scenarios: whether a given code matches a given pair of previous and current samples, the blind first sample after arming, AND versus OR with the external term, and accumulation of matching samples that are not consecutive. The bench checks these against a model computed from the requirements, using exhaustive sweeps and a long pseudo-random run with periodic re-arming.

// File: rtl/trig_seq_pkg.sv
package trig_seq_pkg;

  typedef enum logic [2:0] {
    COND_ANY  = 3'd0,
    COND_LOW  = 3'd1,
    COND_HIGH = 3'd2,
    COND_RISE = 3'd3,
    COND_FALL = 3'd4,
    COND_EDGE = 3'd5
  } cond_e;

  typedef struct packed {
    logic clrHist;   // forget previous sample (arm)
    logic sample;    // capture current sample as history
    logic clrCnt;    // empty the event counter
    logic incCnt;    // count one matching sample
  } seq_strobe_t;

endpackage

// File: rtl/trig_match.sv
module trig_match
  import trig_seq_pkg::*;
#(
  parameter int PROBE_W    = 8,
  parameter int NUM_LEVELS = 10,
  parameter int CNT_W      = 8,
  parameter int LVL_W      = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  seq_strobe_t                   strobe,
  input  logic [LVL_W-1:0]              levelIdx,
  input  logic [PROBE_W-1:0]            probe,
  input  logic                          extTrigIn,
  input  logic [NUM_LEVELS*PROBE_W*3-1:0] condCfg,
  input  logic [NUM_LEVELS-1:0]         orMode,
  input  logic [NUM_LEVELS-1:0]         extUse,
  input  logic [NUM_LEVELS*CNT_W-1:0]   countCfg,
  output logic                          levelMatch,
  output logic                          levelMet
);

  localparam int LVL_BITS = PROBE_W * 3;

  logic [PROBE_W-1:0] prevProbe;
  logic               prevValid;
  logic [CNT_W-1:0]   hitCnt;
  logic [LVL_BITS-1:0] curCfg;
  logic [CNT_W-1:0]   curTarget;
  logic [PROBE_W-1:0] bitRel;
  logic [PROBE_W-1:0] bitHit;
  logic [PROBE_W:0]   termRel;
  logic [PROBE_W:0]   termHit;

  always_ff @(posedge clk) begin
    if (!rst_n || strobe.clrHist) begin
      prevProbe <= '0;
      prevValid <= 1'b0;
    end else if (strobe.sample) begin
      prevProbe <= probe;
      prevValid <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || strobe.clrCnt) hitCnt <= '0;
    else if (strobe.incCnt)      hitCnt <= hitCnt + 1'b1;
  end

  always_comb begin
    curCfg    = condCfg[int'(levelIdx)*LVL_BITS +: LVL_BITS];
    curTarget = countCfg[int'(levelIdx)*CNT_W +: CNT_W];
  end

  for (genvar b = 0; b < PROBE_W; b++) begin : g_bit
    logic [2:0] code;
    assign code = curCfg[b*3 +: 3];
    always_comb begin
      bitRel[b] = 1'b1;
      bitHit[b] = 1'b0;
      case (code)
        COND_LOW:  bitHit[b] = !probe[b];
        COND_HIGH: bitHit[b] = probe[b];
        COND_RISE: bitHit[b] = prevValid && !prevProbe[b] && probe[b];
        COND_FALL: bitHit[b] = prevValid && prevProbe[b] && !probe[b];
        COND_EDGE: bitHit[b] = prevValid && (prevProbe[b] ^ probe[b]);
        default:   bitRel[b] = 1'b0;
      endcase
    end
  end

  always_comb begin
    termRel = {extUse[levelIdx], bitRel};
    termHit = {extTrigIn, bitHit} & termRel;
    if (termRel == '0)          levelMatch = 1'b1;
    else if (orMode[levelIdx])  levelMatch = |termHit;
    else                        levelMatch = (termHit == termRel);
    levelMet = levelMatch &&
               (({1'b0, hitCnt} + 1'b1) >= {1'b0, curTarget});
  end

  // R8
  cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.clrCnt |=> (hitCnt == '0));

  // R8
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.incCnt && !strobe.clrCnt) |=> (hitCnt == $past(hitCnt) + 1'b1));

endmodule

// File: rtl/trig_ctrl.sv
module trig_ctrl
  import trig_seq_pkg::*;
#(
  parameter int NUM_LEVELS = 10,
  parameter int LVL_W      = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic             levelMatch,
  input  logic             levelMet,
  output seq_strobe_t      strobe,
  output logic [LVL_W-1:0] levelIdx,
  output logic             running,
  output logic             trigOut
);

  localparam logic [LVL_W-1:0] LAST_LVL = LVL_W'(NUM_LEVELS - 1);

  logic advance;
  assign advance = running && !arm && levelMet;

  always_comb begin
    strobe.clrHist = arm;
    strobe.sample  = running && !arm;
    strobe.clrCnt  = arm || advance;
    strobe.incCnt  = running && !arm && levelMatch && !levelMet;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running  <= 1'b0;
      levelIdx <= '0;
      trigOut  <= 1'b0;
    end else begin
      trigOut <= 1'b0;
      if (arm) begin
        running  <= 1'b1;
        levelIdx <= '0;
      end else if (advance) begin
        if (levelIdx == LAST_LVL) begin
          running <= 1'b0;
          trigOut <= 1'b1;
        end else begin
          levelIdx <= levelIdx + 1'b1;
        end
      end
    end
  end

  // R2
  arm_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> (running && levelIdx == '0));

  // R9
  single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !arm) |=> (!running || levelIdx == $past(levelIdx) ||
                           levelIdx == $past(levelIdx) + 1'b1));

  // R10
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trigOut |=> !trigOut);

  // R10
  fire_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trigOut |-> ($past(running) && $past(levelIdx) == LAST_LVL && !running));

endmodule

// File: rtl/trig_sequencer.sv
module trig_sequencer
  import trig_seq_pkg::*;
#(
  parameter int PROBE_W    = 8,
  parameter int NUM_LEVELS = 10,
  parameter int CNT_W      = 8,
  localparam int LVL_W     = (NUM_LEVELS > 1) ? $clog2(NUM_LEVELS) : 1
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            arm,
  input  logic [PROBE_W-1:0]              probe,
  input  logic                            extTrigIn,
  input  logic [NUM_LEVELS*PROBE_W*3-1:0] condCfg,
  input  logic [NUM_LEVELS-1:0]           orMode,
  input  logic [NUM_LEVELS-1:0]           extUse,
  input  logic [NUM_LEVELS*CNT_W-1:0]     countCfg,
  output logic                            trigOut,
  output logic                            running,
  output logic [LVL_W-1:0]                levelIdx
);

  seq_strobe_t strobe;
  logic        levelMatch;
  logic        levelMet;

  trig_ctrl #(.NUM_LEVELS(NUM_LEVELS), .LVL_W(LVL_W)) i_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .arm        (arm),
    .levelMatch (levelMatch),
    .levelMet   (levelMet),
    .strobe     (strobe),
    .levelIdx   (levelIdx),
    .running    (running),
    .trigOut    (trigOut)
  );

  trig_match #(.PROBE_W(PROBE_W), .NUM_LEVELS(NUM_LEVELS), .CNT_W(CNT_W),
               .LVL_W(LVL_W)) i_match (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (strobe),
    .levelIdx   (levelIdx),
    .probe      (probe),
    .extTrigIn  (extTrigIn),
    .condCfg    (condCfg),
    .orMode     (orMode),
    .extUse     (extUse),
    .countCfg   (countCfg),
    .levelMatch (levelMatch),
    .levelMet   (levelMet)
  );

endmodule

// File: tb/test_trig_sequencer.sv
module test_trig_sequencer;

  localparam int PW = 4;
  localparam int NL = 3;
  localparam int CW = 3;
  localparam int LW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic arm = 1'b0;
  logic [PW-1:0] probe = '0;
  logic extTrigIn = 1'b0;
  logic [NL*PW*3-1:0] condCfg;
  logic [NL-1:0] orMode, extUse;
  logic [NL*CW-1:0] countCfg;
  logic trigOut, running;
  logic [LW-1:0] levelIdx;

  logic [2:0]    cfgCode [NL][PW];
  logic [CW-1:0] cfgCnt  [NL];
  logic          cfgOr   [NL];
  logic          cfgExt  [NL];

  int checks = 0;
  int errors = 0;
  string phase = "R1";

  always #2 clk = ~clk;

  always_comb begin
    for (int l = 0; l < NL; l++) begin
      for (int b = 0; b < PW; b++) condCfg[(l*PW+b)*3 +: 3] = cfgCode[l][b];
      countCfg[l*CW +: CW] = cfgCnt[l];
      orMode[l] = cfgOr[l];
      extUse[l] = cfgExt[l];
    end
  end

  trig_sequencer #(.PROBE_W(PW), .NUM_LEVELS(NL), .CNT_W(CW)) i_trig_sequencer (
    .clk(clk), .rst_n(rst_n), .arm(arm), .probe(probe), .extTrigIn(extTrigIn),
    .condCfg(condCfg), .orMode(orMode), .extUse(extUse), .countCfg(countCfg),
    .trigOut(trigOut), .running(running), .levelIdx(levelIdx)
  );

  // reference model built from the requirements
  logic mRun, mTrig, mPv;
  int   mLvl, mCnt;
  logic [PW-1:0] mPrev;

  function automatic logic mdlMatch(int l, logic [PW-1:0] p, logic [PW-1:0] q,
                                    logic pv, logic e);
    int rel = 0;
    int hit = 0;
    for (int b = 0; b < PW; b++) begin
      case (cfgCode[l][b])
        3'd1: begin rel++; if (!p[b]) hit++; end
        3'd2: begin rel++; if (p[b]) hit++; end
        3'd3: begin rel++; if (pv && !q[b] && p[b]) hit++; end
        3'd4: begin rel++; if (pv && q[b] && !p[b]) hit++; end
        3'd5: begin rel++; if (pv && (q[b] != p[b])) hit++; end
        default: ;
      endcase
    end
    if (cfgExt[l]) begin rel++; if (e) hit++; end
    if (rel == 0) return 1'b1;
    return cfgOr[l] ? (hit > 0) : (hit == rel);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mRun <= 0; mTrig <= 0; mPv <= 0; mLvl <= 0; mCnt <= 0; mPrev <= '0;
    end else begin
      mTrig <= 0;
      if (arm) begin
        mRun <= 1; mLvl <= 0; mCnt <= 0; mPv <= 0;
      end else if (mRun) begin
        mPrev <= probe; mPv <= 1;
        if (mdlMatch(mLvl, probe, mPrev, mPv, extTrigIn)) begin
          if (mCnt + 1 >= ((cfgCnt[mLvl] == 0) ? 1 : int'(cfgCnt[mLvl]))) begin
            mCnt <= 0;
            if (mLvl == NL - 1) begin mRun <= 0; mTrig <= 1; end
            else mLvl <= mLvl + 1;
          end else mCnt <= mCnt + 1;
        end
      end
    end
  end

  task automatic chk(logic ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // one sample clock; compare every output with the model afterwards
  task automatic cyc(logic a, logic [PW-1:0] p, logic e);
    arm = a; probe = p; extTrigIn = e;
    @(posedge clk); #1;
    chk(trigOut == mTrig, {phase, " trigOut"}, int'(trigOut), int'(mTrig));
    chk(running == mRun, {phase, " running"}, int'(running), int'(mRun));
    chk(int'(levelIdx) == mLvl, {phase, " levelIdx"}, int'(levelIdx), mLvl);
  endtask

  task automatic clearCfg();
    for (int l = 0; l < NL; l++) begin
      for (int b = 0; b < PW; b++) cfgCode[l][b] = 3'd0;
      cfgCnt[l] = '0; cfgOr[l] = 0; cfgExt[l] = 0;
    end
  endtask

  function automatic logic codeHit(int c, logic q, logic p, logic first);
    case (c)
      1: return !p;
      2: return p;
      3: return !first && !q && p;
      4: return !first && q && !p;
      5: return !first && (q != p);
      default: return 1'b1;
    endcase
  endfunction

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    clearCfg();
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk(trigOut == 0 && running == 0 && levelIdx == 0, "R1 reset",
        int'({trigOut, running, levelIdx}), 0);
    rst_n = 1'b1;
    cyc(0, 4'hF, 1);
    chk(running == 0 && trigOut == 0, "R1 idle without arm", int'(running), 0);

    // R3 R4 R6: every code on bit 0, every pair of samples, on the first
    // sample after arming and on a later one
    for (int c = 0; c < 8; c++) begin
      for (int pr = 0; pr < 4; pr++) begin
        clearCfg();
        cfgCode[0][0] = 3'(c);
        phase = (c == 1 || c == 2) ? "R3" : (c >= 3 && c <= 5) ? "R4" : "R6";
        cyc(1, 4'h0, 0);
        cyc(0, {3'b0, pr[1]}, 0);
        // fired on the first sample means level0 left after one clock
        chk(((levelIdx != 0) || !running) == codeHit(c, 1'b0, pr[1], 1'b1),
            {phase, " first sample"}, int'(levelIdx), 0);
        cyc(0, {3'b0, pr[0]}, 0);
        repeat (3) cyc(0, {3'b0, pr[0]}, 0);
      end
    end

    // R4: edge codes never match on the first sample even after a change
    clearCfg();
    phase = "R4";
    cfgCode[0][1] = 3'd5;
    cyc(0, 4'h0, 0);
    cyc(1, 4'h0, 0);
    cyc(0, 4'h2, 0);
    chk(levelIdx == 0 && running, "R4 blind first sample", int'(levelIdx), 0);
    cyc(0, 4'h0, 0);
    chk(levelIdx == 1, "R4 edge after history", int'(levelIdx), 1);

    // R5 R7: two high bits plus the external term, AND and OR, all inputs
    for (int m = 0; m < 2; m++) begin
      for (int v = 0; v < 8; v++) begin
        clearCfg();
        phase = "R5";
        cfgCode[0][0] = 3'd2; cfgCode[0][2] = 3'd2;
        cfgExt[0] = 1; cfgOr[0] = m[0];
        cyc(1, 4'h0, 0);
        cyc(0, {1'b0, v[1], 1'b1, v[0]}, v[2]);
        chk((levelIdx == 1) == (m == 1 ? (v != 0) : (v == 7)), "R5 R7 combine",
            int'(levelIdx), (m == 1 ? int'(v != 0) : int'(v == 7)));
        cyc(0, 4'h0, 0);
      end
    end

    // R8: count of 3 on level 1 with gaps between matches
    clearCfg();
    phase = "R8";
    cfgCode[1][3] = 3'd2; cfgCnt[1] = 3'd3;
    cyc(1, 4'h0, 0);
    cyc(0, 4'h0, 0);
    cyc(0, 4'h8, 0);
    cyc(0, 4'h0, 0);
    cyc(0, 4'h8, 0);
    chk(levelIdx == 1, "R8 two of three", int'(levelIdx), 1);
    cyc(0, 4'h0, 0);
    cyc(0, 4'h8, 0);
    chk(levelIdx == 2, "R8 third match", int'(levelIdx), 2);

    // R9 R10: all don't-care fires after exactly NL samples
    clearCfg();
    phase = "R10";
    cyc(1, 4'h0, 0);
    cyc(0, 4'h0, 0);
    chk(levelIdx == 1, "R9 one step per clock", int'(levelIdx), 1);
    cyc(0, 4'h0, 0);
    cyc(0, 4'h0, 0);
    chk(trigOut == 1 && running == 0, "R10 fire", int'(trigOut), 1);
    cyc(0, 4'h0, 0);
    chk(trigOut == 0, "R10 pulse width", int'(trigOut), 0);
    repeat (3) cyc(0, 4'hF, 1);
    chk(running == 0 && trigOut == 0, "R10 ignored after fire", int'(running), 0);

    // R2 R9 R10: long pseudo-random run with re-arming
    begin
      logic [15:0] lfsr = 16'hACE1;
      for (int k = 0; k < 4000; k++) begin
        if (k % 200 == 0) begin
          for (int l = 0; l < NL; l++) begin
            for (int b = 0; b < PW; b++) begin
              lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
              cfgCode[l][b] = (lfsr[3:0] < 4'd9) ? 3'd0 : lfsr[6:4];
            end
            cfgCnt[l] = lfsr[9:7]; cfgOr[l] = lfsr[10]; cfgExt[l] = lfsr[11];
          end
        end
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        phase = "R2 R9";
        cyc((lfsr[15:11] == 0) || (k % 200 == 0), lfsr[3:0], lfsr[4]);
      end
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule